// File: doc/BRIEF.md
# CPU Clock-Enable Divider with Slow-Region Detection

This block produces a clock-enable for an 8-bit processor that shares a single base clock with the rest of the system. At full rate the enable is high on every base-clock cycle. In divide mode the enable is high for one cycle out of every N cycles, where N is an odd value from 3 to 17 taken from a small control register.

Divide mode is entered in one of two ways. Software can force it permanently through an enable bit in the clock register. Divide mode is also entered automatically while the processor is accessing a memory region flagged as slow. A second register, the bus register, selects which regions count as slow: either half of the cartridge window (whose placement and size also come from the bus register), or the system ROM. Once an access has matched a slow region, the slow rate is held until that access ends. No clock is ever gated; the processor core simply qualifies its flops with the enable.

Top module: `cpu_clk_divider`

## Requirements
- R1: After reset both registers read 0 and the enable is high on every cycle.
- R2: A write to I/O address 0x011A stores bits 3:0 of the write data in the clock register. Bits 2:0 are the divisor field and bit 3 forces divide mode. Reading 0x011A returns the stored nibble with bits 7:4 as zero. Reading any address other than the two register addresses returns 0.
- R3: A write to I/O address 0x0110 stores all 8 bits in the bus register, and reading 0x0110 returns them.
- R4: In divide mode the period is N = 2*(7 - field) + 3, so field 7 gives 3 and field 0 gives 17. The enable is high for exactly one cycle in each period.
- R5: When clock-register bit 3 is clear and no slow access is in progress, the enable is high every cycle.
- R6: On entry to divide mode, the first pulse comes after a full period. A new divisor written during divide mode takes effect only at the next reload after the current pulse, so no period is shortened.
- R7: Bus-register bits 5:4 place the cartridge window: 00 gives 0x5000 with 2 KB halves, 01 gives 0x5000 with 8 KB halves, 10 gives 0x5000 with 16 KB halves, and 11 gives 0x1000 with 8 KB halves. Area 1 is the lower half and area 2 is the upper half. With bus bit 0 set, an access to area 1 selects divide mode.
- R8: With bus bit 1 set, an access to area 2 selects divide mode.
- R9: With bus bit 6 set, an access within 0xD000 to 0xEFFF selects divide mode.
- R10: Once an access has matched an enabled slow region, divide mode holds for as long as the access strobe stays high, even if the address leaves the region.
- R11: An address in a region whose enable bit is clear, or any address presented without the access strobe, leaves the enable at full rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | I/O register write strobe |
| reg_addr | input | 16 | I/O address for register write and read |
| reg_wdata | input | 8 | I/O write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| mem_access | input | 1 | High while a memory access is in progress |
| mem_addr | input | 16 | Address of the access in progress |
| cpu_ce | output | 1 | Clock-enable for the processor |

## Verification
The bench aims at the window edges: the first and last byte of each cartridge half in all four placements, and the byte just past the ROM top. A decoder that is off by one there would slow an access it should not, or miss one it should. It rewrites the divisor in the middle of a period and enters divide mode from full rate; a counter that reloads early would produce a short runt period, or a pulse on the very first slow cycle. It also moves the address out of a slow region while the access strobe is held, which exposes a design that drops back to full rate before the access completes.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    // bus register bit positions (decoded by the slow-region detector)
    localparam int BC_AREA1 = 0;
    localparam int BC_AREA2 = 1;
    localparam int BC_WIN_LO = 4;
    localparam int BC_ROM = 6;
    // clock register bit positions
    localparam int CC_FORCE = 3;

    typedef struct packed {
        logic [3:0]        clk_ctl;
        logic [DATA_W-1:0] bus_ctl;
    } ctl_regs_t;

    typedef struct packed {
        logic [ADDR_W:0] start;
        logic [ADDR_W:0] half;
    } cart_win_t;

    function automatic cart_win_t cart_window(input logic [1:0] mode);
        cart_win_t w;
        case (mode)
            2'b00:   begin w.start = 17'h05000; w.half = 17'h00800; end
            2'b01:   begin w.start = 17'h05000; w.half = 17'h02000; end
            2'b10:   begin w.start = 17'h05000; w.half = 17'h04000; end
            default: begin w.start = 17'h01000; w.half = 17'h02000; end
        endcase
        return w;
    endfunction

endpackage

// File: rtl/ctl_regs.sv
module ctl_regs
    import cpuclk_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CLK_REG_ADDR = 16'h011A,
    parameter logic [ADDR_W-1:0] BUS_REG_ADDR = 16'h0110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output ctl_regs_t         regs
);
    ctl_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (reg_wr && reg_addr == CLK_REG_ADDR) regs_d.clk_ctl = reg_wdata[3:0];
        if (reg_wr && reg_addr == BUS_REG_ADDR) regs_d.bus_ctl = reg_wdata;
        if (reg_addr == CLK_REG_ADDR)      reg_rdata = {4'b0, regs_q.clk_ctl};
        else if (reg_addr == BUS_REG_ADDR) reg_rdata = regs_q.bus_ctl;
        else                               reg_rdata = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;

    p_clk_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == CLK_REG_ADDR |=> regs_q.clk_ctl == $past(reg_wdata[3:0]));
    p_clk_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == CLK_REG_ADDR |-> reg_rdata[7:4] == 4'b0);
    p_bus_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == BUS_REG_ADDR |=> regs_q.bus_ctl == $past(reg_wdata));
endmodule

// File: rtl/slow_detect.sv
module slow_detect
    import cpuclk_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ROM_LO = 16'hD000,
    parameter logic [ADDR_W-1:0] ROM_HI = 16'hEFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_ctl,
    input  logic              mem_access,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic              slow_req
);
    typedef struct packed {
        logic hold;
    } det_state_t;

    det_state_t st_d, st_q;
    cart_win_t  win;
    logic [ADDR_W:0] addr_x, end1, end2;
    logic in_area1, in_area2, in_rom, hit;

    always_comb begin
        win      = cart_window(bus_ctl[BC_WIN_LO+1:BC_WIN_LO]);
        addr_x   = {1'b0, mem_addr};
        end1     = win.start + win.half;
        end2     = end1 + win.half;
        in_area1 = (addr_x >= win.start) && (addr_x < end1);
        in_area2 = (addr_x >= end1) && (addr_x < end2);
        in_rom   = (mem_addr >= ROM_LO) && (mem_addr <= ROM_HI);
        hit      = (bus_ctl[BC_AREA1] && in_area1) ||
                   (bus_ctl[BC_AREA2] && in_area2) ||
                   (bus_ctl[BC_ROM] && in_rom);
        slow_req = mem_access && (hit || st_q.hold);
        st_d.hold = slow_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_access && hit |=> (!mem_access || slow_req));
    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_access |-> !slow_req);
endmodule

// File: rtl/ce_divider.sv
module ce_divider #(
    parameter int FIELD_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] field,
    input  logic               divide,
    output logic               ce
);
    localparam int MAX_DIV = 2 * (2**FIELD_W - 1) + 3;
    localparam int CNT_W   = $clog2(MAX_DIV);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [CNT_W-1:0] reload;

    always_comb begin
        reload = CNT_W'({~field, 1'b0}) + CNT_W'(2);
        st_d   = st_q;
        if (!divide) begin
            ce         = 1'b1;
            st_d.cnt   = reload;
        end else begin
            ce         = (st_q.cnt == '0);
            st_d.cnt   = ce ? reload : st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_full_rate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !divide |-> ce);
    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        divide && ce |=> (!divide || !ce));
    p_no_runt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        divide && ce |=> (!divide || !$past(ce, 1) || !ce));
endmodule

// File: rtl/cpu_clk_divider.sv
module cpu_clk_divider
    import cpuclk_pkg::*;
#(
    parameter logic [15:0] CLK_REG_ADDR = 16'h011A,
    parameter logic [15:0] BUS_REG_ADDR = 16'h0110,
    parameter logic [15:0] ROM_LO       = 16'hD000,
    parameter logic [15:0] ROM_HI       = 16'hEFFF,
    parameter int          FIELD_W      = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [15:0] reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        mem_access,
    input  logic [15:0] mem_addr,
    output logic        cpu_ce
);
    ctl_regs_t regs;
    logic      slow_req;
    logic      divide;

    ctl_regs #(.CLK_REG_ADDR(CLK_REG_ADDR), .BUS_REG_ADDR(BUS_REG_ADDR)) i_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .regs(regs)
    );

    slow_detect #(.ROM_LO(ROM_LO), .ROM_HI(ROM_HI)) i_detect (
        .clk(clk), .rst_n(rst_n), .bus_ctl(regs.bus_ctl),
        .mem_access(mem_access), .mem_addr(mem_addr), .slow_req(slow_req)
    );

    assign divide = regs.clk_ctl[CC_FORCE] || slow_req;

    ce_divider #(.FIELD_W(FIELD_W)) i_div (
        .clk(clk), .rst_n(rst_n), .field(regs.clk_ctl[FIELD_W-1:0]),
        .divide(divide), .ce(cpu_ce)
    );

    p_reset_full_r1: assert property (@(posedge clk)
        !rst_n |=> cpu_ce);
endmodule

// File: tb/test_cpu_clk_divider.sv
module test_cpu_clk_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_addr = 16'h0000;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        mem_access = 1'b0;
    logic [15:0] mem_addr = 16'h0000;
    logic        cpu_ce;

    always #5 clk = ~clk;

    cpu_clk_divider i_cpu_clk_divider (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_access(mem_access),
        .mem_addr(mem_addr), .cpu_ce(cpu_ce)
    );

    int checks = 0;
    int fails = 0;
    string req = "R1";
    bit done = 0;

    // reference model state
    int m_cc = 0, m_bc = 0, m_cnt = 0, m_hold = 0;

    function automatic int region_hit(int bc, int a);
        int lo, h;
        case ((bc >> 4) & 3)
            0: begin lo = 20480; h = 2048;  end
            1: begin lo = 20480; h = 8192;  end
            2: begin lo = 20480; h = 16384; end
            default: begin lo = 4096; h = 8192; end
        endcase
        if ((bc & 1) && a >= lo && a < lo + h) return 1;
        if ((bc & 2) && a >= lo + h && a < lo + 2 * h) return 1;
        if ((bc & 64) && a >= 53248 && a <= 61439) return 1;
        return 0;
    endfunction

    task automatic check(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // called at negedge with inputs settled; ends at next negedge
    task automatic tick();
        int slow, dv, n, exp_ce, exp_rd, nx_cnt;
        #1;
        slow   = mem_access && (region_hit(m_bc, int'(mem_addr)) || m_hold);
        dv     = ((m_cc & 8) != 0) || slow;
        n      = (7 - (m_cc & 7)) * 2 + 3;
        exp_ce = dv ? (m_cnt == 0) : 1;
        exp_rd = (reg_addr == 16'h0110) ? m_bc : (reg_addr == 16'h011A) ? m_cc : 0;
        check(int'(cpu_ce), exp_ce, "cpu_ce");
        check(int'(reg_rdata), exp_rd, "reg_rdata");
        nx_cnt = dv ? ((m_cnt == 0) ? n - 1 : m_cnt - 1) : n - 1;
        @(posedge clk);
        m_cnt  = nx_cnt;
        m_hold = slow;
        if (reg_wr && reg_addr == 16'h011A) m_cc = int'(reg_wdata) & 15;
        if (reg_wr && reg_addr == 16'h0110) m_bc = int'(reg_wdata);
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic access(input logic [15:0] a, input int n);
        mem_access = 1'b1; mem_addr = a;
        run(n);
        mem_access = 1'b0;
        run(2);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values, full rate
        req = "R1";
        reg_addr = 16'h0110; run(3);
        reg_addr = 16'h011A; run(3);
        // R3: bus register readback
        req = "R3";
        wr(16'h0110, 8'hA5); reg_addr = 16'h0110; run(2);
        wr(16'h0110, 8'h00); run(1);
        // R2: clock register nibble, other addresses read zero
        req = "R2";
        wr(16'h011A, 8'hF5); reg_addr = 16'h011A; run(2);
        reg_addr = 16'h0112; run(2);
        // R5: field set but force bit clear, no access
        req = "R5";
        wr(16'h011A, 8'h02); mem_addr = 16'hD100; run(6);
        // R4: forced divide at several divisors
        req = "R4";
        wr(16'h011A, 8'h08); run(40);
        wr(16'h011A, 8'h0F); run(12);
        wr(16'h011A, 8'h0B); run(25);
        // R6: divisor change mid-period, and re-entry
        req = "R6";
        run(3); wr(16'h011A, 8'h0E); run(20);
        wr(16'h011A, 8'h06); run(4);
        wr(16'h011A, 8'h0C); run(15);
        wr(16'h011A, 8'h07); run(3);
        // R7 / R8: cartridge halves in every placement, edges included
        for (int mode = 0; mode < 4; mode++) begin
            int lo, h;
            lo = (mode == 3) ? 4096 : 20480;
            h  = (mode == 0) ? 2048 : (mode == 2) ? 16384 : 8192;
            wr(16'h0110, 8'(mode << 4 | 1));
            req = "R7"; access(16'(lo), 8); access(16'(lo + h - 1), 8);
            req = "R11"; access(16'(lo + h), 6); access(16'(lo - 1), 6);
            wr(16'h0110, 8'(mode << 4 | 2));
            req = "R8"; access(16'(lo + h), 8); access(16'(lo + 2 * h - 1), 8);
            req = "R11"; access(16'(lo + 2 * h), 6); access(16'(lo + h - 1), 6);
        end
        // R9: system ROM region
        req = "R9";
        wr(16'h0110, 8'h40);
        access(16'hD000, 8); access(16'hEFFF, 8);
        req = "R11";
        access(16'hF000, 6); access(16'hCFFF, 6);
        // R10: hold while the strobe stays high
        req = "R10";
        mem_access = 1'b1; mem_addr = 16'hD200; run(4);
        mem_addr = 16'h0200; run(12);
        mem_access = 1'b0; run(4);
        // R11: region disabled, and address without strobe
        req = "R11";
        wr(16'h0110, 8'h00); access(16'hD000, 8);
        wr(16'h0110, 8'h43); mem_addr = 16'h5000; run(6);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule